// File: doc/BRIEF.md
# Indexed Forwarded-Result Queue Pair

This block sits in a trailing core that re-executes a thread already run by a leading core. The leading core forwards a small set of values after its instructions retire: the correct targets of branches it mispredicted, and the results of instructions it judged critical. Each forwarded entry carries the position of its instruction inside the current execution chunk and a one-bit chunk tag. The block keeps branch targets and instruction results in two separate in-order queues. The fetch stage presents a branch's chunk index, and on a hit the stored target replaces the predictor's guess. The dispatch stage presents an instruction's chunk index, and on a hit the stored result goes into the register file so that dependants can issue at once.

Because both the sender and the consumers move through a chunk in program order, each queue compares only its oldest entry against the lookup index. A head entry for a later instruction is kept, and a head entry for an instruction already passed is discarded. A chunk-end pulse flips the current chunk tag. Each queue then enters a drain state, in which it removes leftover entries from the finished chunk, one per cycle, and answers every lookup with a miss.

Each queue runs a two-state machine. In state LANE_RUN it serves lookups. The chunk-end pulse takes it through the transition RUN-to-DRAIN into state LANE_DRAIN, which discards old-tag head entries. The transition DRAIN-to-RUN is taken when the queue is empty or its head carries the current tag.

Top module: `fwdq_pair`

## Requirements
- R1: After reset both occupancy counts are 0, `enq_ready_o` is 1 for either queue type, and lookups on the empty queues return no hit.
- R2: An entry offered with `enq_valid_i`=1 and `enq_ready_o`=1 goes to the branch queue when `enq_is_br_i`=1 and to the result queue when `enq_is_br_i`=0. The count of that queue rises by one in the next cycle.
- R3: A fetch lookup hits in the same cycle when the head of the branch queue carries the current chunk tag and an index equal to `fetch_idx_i`. It drives the stored target on `fetch_target_o`, and the entry is freed, so the count falls by one in the next cycle.
- R4: A dispatch lookup behaves in the same way on the result queue. It drives the stored value on `disp_value_o` and frees the entry.
- R5: If the head index is greater than the lookup index, the lookup misses and the entry is kept.
- R6: If the head index is smaller than the lookup index, the lookup misses and the stale head entry is discarded.
- R7: The branch queue holds 64 entries and the result queue holds 512. When a queue is full, `enq_ready_o` is 0 for its type and an offered entry is not stored, while the other queue still accepts entries.
- R8: A lookup and an enqueue in the same cycle are both serviced. The lookup does not see the entry being enqueued.
- R9: A chunk-end pulse flips the current tag, which is 0 after reset. From the next cycle, head entries with the old tag are discarded one per cycle, lookups miss until draining ends, and entries with the new tag are kept.
- R10: An entry whose tag differs from the current tag is never matched. It stays queued and can hit once a chunk-end pulse makes its tag current.
- R11: Each queue presents its current occupancy every cycle, and the occupancy changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chunk_end_i | input | 1 | One-cycle pulse marking the end of the current chunk |
| enq_valid_i | input | 1 | Forwarded entry offered |
| enq_is_br_i | input | 1 | 1: branch target, 0: instruction result |
| enq_tag_i | input | 1 | Chunk tag of the offered entry |
| enq_idx_i | input | IDX_W | Instruction index within the chunk |
| enq_data_i | input | DATA_W | Target address or result value |
| enq_ready_o | output | 1 | Queue selected by `enq_is_br_i` has room |
| fetch_valid_i | input | 1 | Fetch-side lookup request |
| fetch_idx_i | input | IDX_W | Chunk index of the fetched branch |
| fetch_hit_o | output | 1 | Stored target overrides the predictor |
| fetch_target_o | output | DATA_W | Stored branch target, 0 on miss |
| disp_valid_i | input | 1 | Dispatch-side lookup request |
| disp_idx_i | input | IDX_W | Chunk index of the dispatched instruction |
| disp_hit_o | output | 1 | Stored result available |
| disp_value_o | output | DATA_W | Stored result, 0 on miss |
| br_count_o | output | $clog2(BR_DEPTH+1) | Branch queue occupancy |
| res_count_o | output | $clog2(RES_DEPTH+1) | Result queue occupancy |

## Verification
A wrong pointer or count shows up at the next lookup. Either the wrong stored data comes out on a hit, or a hit is missing or extra, and the occupancy output is off in the cycle after the faulty update. A queue stuck in the drain state answers every later lookup with a miss. A faulty drain shows up as a changed count a few cycles after the chunk-end pulse, on the number of entries that remain. A wrong full decision either lowers `enq_ready_o` early or lets the count pass the capacity in the cycle after the enqueue.

// File: rtl/fwdq_pkg.sv
package fwdq_pkg;

    // queue lane control states
    typedef enum logic {
        LANE_RUN   = 1'b0,
        LANE_DRAIN = 1'b1
    } lane_state_e;

    // outcome of comparing the oldest entry against a lookup
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_STALE = 2'd2,
        LK_AHEAD = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/fwdq_store.sv
module fwdq_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/fwdq_lane.sv
module fwdq_lane
    import fwdq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int EW    = 1 + IDX_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              cur_tag_i,
    input  logic              push_i,
    input  logic              push_tag_i,
    input  logic [IDX_W-1:0]  push_idx_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              lk_valid_i,
    input  logic [IDX_W-1:0]  lk_idx_i,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o,
    output logic [CW-1:0]     count_o,
    output logic              full_o
);

    lane_state_e state_q, state_d;
    lk_kind_e    kind;

    logic [AW-1:0]     rd_ptr_q, wr_ptr_q;
    logic [CW-1:0]     count_q;
    logic [EW-1:0]     head;
    logic              h_tag;
    logic [IDX_W-1:0]  h_idx;
    logic [DATA_W-1:0] h_data;
    logic              head_vld;
    logic              full;
    logic              accept;
    logic              drain_pop;
    logic              pop;

    fwdq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk     (clk),
        .we_i    (accept),
        .waddr_i (wr_ptr_q),
        .wdata_i ({push_tag_i, push_idx_i, push_data_i}),
        .raddr_i (rd_ptr_q),
        .rdata_o (head)
    );

    assign h_tag    = head[EW-1];
    assign h_idx    = head[DATA_W +: IDX_W];
    assign h_data   = head[DATA_W-1:0];
    assign head_vld = (count_q != '0);
    assign full     = (count_q == CW'(DEPTH));
    assign accept   = push_i && !full;

    // classify the oldest entry against the lookup
    always_comb begin
        kind = LK_NONE;
        if (state_q == LANE_RUN && lk_valid_i && head_vld && h_tag == cur_tag_i) begin
            if (h_idx == lk_idx_i) begin
                kind = LK_HIT;
            end else if (h_idx < lk_idx_i) begin
                kind = LK_STALE;
            end else begin
                kind = LK_AHEAD;
            end
        end
    end

    assign drain_pop = (state_q == LANE_DRAIN) && head_vld && (h_tag != cur_tag_i);
    assign pop       = (kind == LK_HIT) || (kind == LK_STALE) || drain_pop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LANE_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_RUN: begin
                if (flush_i) begin
                    state_d = LANE_DRAIN;
                end
            end
            LANE_DRAIN: begin
                if (!flush_i && (!head_vld || h_tag == cur_tag_i)) begin
                    state_d = LANE_RUN;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        lk_hit_o  = (kind == LK_HIT);
        lk_data_o = (kind == LK_HIT) ? h_data : '0;
        count_o   = count_q;
        full_o    = full;
    end

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept) begin
                wr_ptr_q <= wrap_inc(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= wrap_inc(rd_ptr_q);
            end
            count_q <= count_q + CW'(accept) - CW'(pop);
        end
    end

endmodule

// File: rtl/fwdq_pair.sv
module fwdq_pair #(
    parameter int BR_DEPTH  = 64,
    parameter int RES_DEPTH = 512,
    parameter int IDX_W     = 10,
    parameter int DATA_W    = 32,
    localparam int BR_CW    = $clog2(BR_DEPTH + 1),
    localparam int RES_CW   = $clog2(RES_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chunk_end_i,
    input  logic              enq_valid_i,
    input  logic              enq_is_br_i,
    input  logic              enq_tag_i,
    input  logic [IDX_W-1:0]  enq_idx_i,
    input  logic [DATA_W-1:0] enq_data_i,
    output logic              enq_ready_o,
    input  logic              fetch_valid_i,
    input  logic [IDX_W-1:0]  fetch_idx_i,
    output logic              fetch_hit_o,
    output logic [DATA_W-1:0] fetch_target_o,
    input  logic              disp_valid_i,
    input  logic [IDX_W-1:0]  disp_idx_i,
    output logic              disp_hit_o,
    output logic [DATA_W-1:0] disp_value_o,
    output logic [BR_CW-1:0]  br_count_o,
    output logic [RES_CW-1:0] res_count_o
);

    logic cur_tag_q;
    logic br_full, res_full;
    logic br_push, res_push;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tag_q <= 1'b0;
        end else if (chunk_end_i) begin
            cur_tag_q <= !cur_tag_q;
        end
    end

    assign enq_ready_o = enq_is_br_i ? !br_full : !res_full;
    assign br_push     = enq_valid_i && enq_is_br_i && !br_full;
    assign res_push    = enq_valid_i && !enq_is_br_i && !res_full;

    fwdq_lane #(.DEPTH(BR_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_br (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (chunk_end_i),
        .cur_tag_i   (cur_tag_q),
        .push_i      (br_push),
        .push_tag_i  (enq_tag_i),
        .push_idx_i  (enq_idx_i),
        .push_data_i (enq_data_i),
        .lk_valid_i  (fetch_valid_i),
        .lk_idx_i    (fetch_idx_i),
        .lk_hit_o    (fetch_hit_o),
        .lk_data_o   (fetch_target_o),
        .count_o     (br_count_o),
        .full_o      (br_full)
    );

    fwdq_lane #(.DEPTH(RES_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (chunk_end_i),
        .cur_tag_i   (cur_tag_q),
        .push_i      (res_push),
        .push_tag_i  (enq_tag_i),
        .push_idx_i  (enq_idx_i),
        .push_data_i (enq_data_i),
        .lk_valid_i  (disp_valid_i),
        .lk_idx_i    (disp_idx_i),
        .lk_hit_o    (disp_hit_o),
        .lk_data_o   (disp_value_o),
        .count_o     (res_count_o),
        .full_o      (res_full)
    );

endmodule

// File: rtl/fwdq_pair_chk.sv
module fwdq_pair_chk #(
    parameter int BR_DEPTH  = 64,
    parameter int RES_DEPTH = 512,
    parameter int IDX_W     = 10,
    parameter int DATA_W    = 32,
    localparam int BR_CW    = $clog2(BR_DEPTH + 1),
    localparam int RES_CW   = $clog2(RES_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chunk_end_i,
    input logic              enq_valid_i,
    input logic              enq_is_br_i,
    input logic              enq_ready_o,
    input logic              fetch_valid_i,
    input logic              fetch_hit_o,
    input logic              disp_valid_i,
    input logic              disp_hit_o,
    input logic [BR_CW-1:0]  br_count_o,
    input logic [RES_CW-1:0] res_count_o
);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(br_count_o) <= BR_DEPTH) && (int'(res_count_o) <= RES_DEPTH));

    assert_full_refuse_br_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_is_br_i && int'(br_count_o) == BR_DEPTH) |-> !enq_ready_o);

    assert_full_refuse_res_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_is_br_i && int'(res_count_o) == RES_DEPTH) |-> !enq_ready_o);

    assert_fetch_hit_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit_o |-> fetch_valid_i);

    assert_disp_hit_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_hit_o |-> disp_valid_i);

    assert_drain_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chunk_end_i) |-> (!fetch_hit_o && !disp_hit_o));

    assert_enq_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid_i && enq_ready_o && enq_is_br_i) |=> (br_count_o >= $past(br_count_o)));

    assert_step_br_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(br_count_o) <= int'($past(br_count_o)) + 1) &&
        (int'(br_count_o) + 1 >= int'($past(br_count_o))));

    assert_step_res_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(res_count_o) <= int'($past(res_count_o)) + 1) &&
        (int'(res_count_o) + 1 >= int'($past(res_count_o))));

endmodule

bind fwdq_pair fwdq_pair_chk #(
    .BR_DEPTH(BR_DEPTH), .RES_DEPTH(RES_DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_fwdq_pair.sv
module tb_fwdq_pair;

    localparam int IDX_W  = 10;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chunk_end_i = 1'b0;
    logic              enq_valid_i = 1'b0;
    logic              enq_is_br_i = 1'b0;
    logic              enq_tag_i = 1'b0;
    logic [IDX_W-1:0]  enq_idx_i = '0;
    logic [DATA_W-1:0] enq_data_i = '0;
    logic              enq_ready_o;
    logic              fetch_valid_i = 1'b0;
    logic [IDX_W-1:0]  fetch_idx_i = '0;
    logic              fetch_hit_o;
    logic [DATA_W-1:0] fetch_target_o;
    logic              disp_valid_i = 1'b0;
    logic [IDX_W-1:0]  disp_idx_i = '0;
    logic              disp_hit_o;
    logic [DATA_W-1:0] disp_value_o;
    logic [6:0]        br_count_o;
    logic [9:0]        res_count_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = !clk;

    fwdq_pair dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enq(input logic br, input logic tag, input int idx, input logic [31:0] d);
        enq_valid_i = 1'b1;
        enq_is_br_i = br;
        enq_tag_i   = tag;
        enq_idx_i   = IDX_W'(idx);
        enq_data_i  = d;
        @(negedge clk);
        enq_valid_i = 1'b0;
    endtask

    task automatic fetch(input int idx, output logic hit, output logic [31:0] tgt);
        fetch_valid_i = 1'b1;
        fetch_idx_i   = IDX_W'(idx);
        #2;
        hit = fetch_hit_o;
        tgt = fetch_target_o;
        @(negedge clk);
        fetch_valid_i = 1'b0;
    endtask

    task automatic disp(input int idx, output logic hit, output logic [31:0] v);
        disp_valid_i = 1'b1;
        disp_idx_i   = IDX_W'(idx);
        #2;
        hit = disp_hit_o;
        v   = disp_value_o;
        @(negedge clk);
        disp_valid_i = 1'b0;
    endtask

    task automatic pulse_chunk_end();
        chunk_end_i = 1'b1;
        @(negedge clk);
        chunk_end_i = 1'b0;
    endtask

    task automatic t_reset();
        logic h; logic [31:0] v;
        chk("R1 br_count", 32'(br_count_o), 0);
        chk("R1 res_count", 32'(res_count_o), 0);
        enq_is_br_i = 1'b1; #1;
        chk("R1 ready br", 32'(enq_ready_o), 1);
        enq_is_br_i = 1'b0; #1;
        chk("R1 ready res", 32'(enq_ready_o), 1);
        fetch(0, h, v);
        chk("R1 fetch miss", 32'(h), 0);
        disp(0, h, v);
        chk("R1 disp miss", 32'(h), 0);
    endtask

    task automatic t_route_and_fetch();
        logic h; logic [31:0] v;
        enq(1'b1, 1'b0, 5, 32'hA0A0_0005);
        chk("R2 br_count after br enq", 32'(br_count_o), 1);
        chk("R2 res_count after br enq", 32'(res_count_o), 0);
        enq(1'b0, 1'b0, 3, 32'hB0B0_0003);
        chk("R2 res_count after res enq", 32'(res_count_o), 1);
        fetch(5, h, v);
        chk("R3 fetch hit", 32'(h), 1);
        chk("R3 fetch target", v, 32'hA0A0_0005);
        chk("R3 br_count freed", 32'(br_count_o), 0);
    endtask

    task automatic t_disp_order();
        logic h; logic [31:0] v;
        enq(1'b0, 1'b0, 7, 32'h0000_0707);
        enq(1'b0, 1'b0, 9, 32'h0000_0909);
        chk("R11 res_count three", 32'(res_count_o), 3);
        disp(2, h, v);
        chk("R5 ahead miss", 32'(h), 0);
        chk("R5 entry kept", 32'(res_count_o), 3);
        disp(7, h, v);
        chk("R6 stale miss", 32'(h), 0);
        chk("R6 stale dropped", 32'(res_count_o), 2);
        disp(7, h, v);
        chk("R4 disp hit", 32'(h), 1);
        chk("R4 disp value", v, 32'h0000_0707);
        disp(9, h, v);
        chk("R4 disp value second", v, 32'h0000_0909);
        chk("R4 res_count empty", 32'(res_count_o), 0);
    endtask

    task automatic t_same_cycle();
        logic h; logic [31:0] v;
        enq_valid_i = 1'b1; enq_is_br_i = 1'b0; enq_tag_i = 1'b0;
        enq_idx_i = 10'd4; enq_data_i = 32'h4444;
        disp(4, h, v);
        enq_valid_i = 1'b0;
        chk("R8 same-cycle miss", 32'(h), 0);
        chk("R8 enqueue serviced", 32'(res_count_o), 1);
        disp(4, h, v);
        chk("R8 later hit", v, 32'h4444);
    endtask

    task automatic t_chunk();
        logic h; logic [31:0] v;
        enq(1'b1, 1'b0, 1, 32'h11);
        enq(1'b1, 1'b0, 2, 32'h22);
        enq(1'b1, 1'b1, 0, 32'hC0);
        chk("R9 br_count before end", 32'(br_count_o), 3);
        pulse_chunk_end();
        fetch(0, h, v);
        chk("R9 miss while draining", 32'(h), 0);
        repeat (4) @(negedge clk);
        chk("R9 new-tag entry kept", 32'(br_count_o), 1);
        fetch(0, h, v);
        chk("R9 hit after drain", v, 32'hC0);
        enq(1'b1, 1'b0, 0, 32'hD0);
        fetch(0, h, v);
        chk("R10 other tag miss", 32'(h), 0);
        chk("R10 other tag kept", 32'(br_count_o), 1);
        pulse_chunk_end();
        repeat (2) @(negedge clk);
        chk("R10 survives end", 32'(br_count_o), 1);
        fetch(0, h, v);
        chk("R10 hit when current", v, 32'hD0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 512; i++) begin
            enq_valid_i = 1'b1; enq_is_br_i = 1'b0; enq_tag_i = 1'b0;
            enq_idx_i = IDX_W'(i); enq_data_i = 32'(i);
            @(negedge clk);
        end
        enq_valid_i = 1'b0;
        chk("R7 result full count", 32'(res_count_o), 512);
        enq_is_br_i = 1'b0; #1;
        chk("R7 result refused", 32'(enq_ready_o), 0);
        enq_is_br_i = 1'b1; #1;
        chk("R7 branch still open", 32'(enq_ready_o), 1);
        enq(1'b0, 1'b0, 600, 32'hDEAD);
        chk("R7 result not stored", 32'(res_count_o), 512);
        for (int i = 0; i < 64; i++) begin
            enq_valid_i = 1'b1; enq_is_br_i = 1'b1; enq_tag_i = 1'b0;
            enq_idx_i = IDX_W'(i); enq_data_i = 32'(i);
            @(negedge clk);
        end
        enq_valid_i = 1'b0;
        chk("R7 branch full count", 32'(br_count_o), 64);
        enq_is_br_i = 1'b1; #1;
        chk("R7 branch refused", 32'(enq_ready_o), 0);
        enq(1'b1, 1'b0, 70, 32'hBEEF);
        chk("R7 branch not stored", 32'(br_count_o), 64);
        pulse_chunk_end();
        @(negedge clk);
        chk("R11 drain one per cycle", 32'(res_count_o), 511);
        repeat (520) @(negedge clk);
        chk("R9 result drained", 32'(res_count_o), 0);
        chk("R9 branch drained", 32'(br_count_o), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route_and_fetch();
        t_disp_order();
        t_same_cycle();
        t_chunk();
        t_full();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule